// File: doc/BRIEF.md
# Serial Register Access Port

This block is the serial front end of a small timekeeping device. A host reaches a 16-entry byte register file through a four-wire serial link that runs in clock mode 0. The link has a serial clock, a host-to-device data line, a device-to-host data line and a chip select that is active high. The block runs on the device's own fast clock. It passes the three incoming link signals through a short synchronizer and finds the serial clock edges in that clock domain.

Each transfer opens with a command byte. Bit 4 of that byte must be set or the transfer is ignored. Bit 7 chooses the direction, and the low nibble gives the starting register. The data bytes that follow move to or from consecutive registers, and the address wraps from the top of the file to the bottom. A written byte reaches the register file as a single-cycle write strobe, and only once all eight of its bits have arrived. Read data is fetched through a combinational read port just before each byte is shifted out, most significant bit first. Dropping select at any time abandons the transfer and returns the block to waiting for a command.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is asserted and after it is released with select low, `spiMiso` is 0 and `regWe` is 0.
- R2: The command byte is decoded with bit 7 = 0 meaning write, bit 4 = 1 as a required marker, and bits 3:0 as the start address. On a write command, each complete data byte that follows is written to the start address, then to the next address, and so on.
- R3: On a read command (bit 7 = 1, bit 4 = 1), the register at the start address and the ones after it are shifted out on `spiMiso` MSB first. The output changes after falling serial clock edges, so each bit is valid for the host's rising edge. Data arriving on MOSI during a read writes nothing.
- R4: During a burst, in either direction, the address after 0xF is 0x0.
- R5: A command byte with bit 4 = 0 is ignored. No register is written for the rest of that transfer, and `spiMiso` stays 0.
- R6: A write byte is committed only after its eighth bit. If select is dropped partway through a byte, that byte is discarded, and the complete bytes before it remain written.
- R7: Dropping select clears the bit position and the command state. The next transfer is decoded from its first byte as a new command.
- R8: `spiMiso` is 0 while select is low, during the command byte, and throughout write or ignored transfers.
- R9: Every committed byte produces exactly one `regWe` pulse, one clock cycle long.
- R10: When the eighth rising serial clock edge of a byte reaches the synchronizer in the same cycle as the falling edge of select, select wins and the byte is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSck | input | 1 | Serial clock from host (idle low) |
| spiMosi | input | 1 | Serial data from host |
| spiSel | input | 1 | Chip select, active high |
| spiMiso | output | 1 | Serial data to host |
| regRaddr | output | 4 | Register file read address |
| regRdata | input | 8 | Register file read data (combinational) |
| regWe | output | 1 | Register file write strobe |
| regWaddr | output | 4 | Register file write address |
| regWdata | output | 8 | Register file write data |

## Verification
Two events can land in the same device-clock cycle: the final rising serial clock edge that completes a write byte, and the deassertion of select. The bench provokes this by raising the serial clock and lowering select in the same timestep. Both signals then pass through equal synchronizer depths and reach the edge logic together. The bench judges the outcome at the register-file write port. Its behavioural write queue expects no strobe, and a later read of that address must return the older value. A second case drops select after only five bits of a byte, which checks that the complete byte sent just before it is still committed.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_SKIP  = 2'd3
  } xferState_t;

  // strobes from control to datapath, one clock wide each
  typedef struct packed {
    logic shiftIn;   // take one MOSI bit
    logic loadAddr;  // capture start address from command byte
    logic commitWr;  // issue a register write for the completed byte
    logic loadTx;    // fetch next register and present its MSB
    logic shiftTx;   // present next bit of the current byte
    logic clrOut;    // force MISO low
  } strobe_t;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic mosiIn,
  input  logic selIn,
  output logic mosiS,
  output logic selS,
  output logic sckRise,
  output logic sckFall
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] synced;
  logic            sckPrev;

  assign rawIn = {selIn, mosiIn, sckIn};

  for (genvar g = 0; g < NSIG; g++) begin : gSync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= synced[0];
  end

  assign mosiS   = synced[1];
  assign selS    = synced[2];
  // edges only count while select is seen high; select falling wins a tie
  assign sckRise = selS &  synced[0] & ~sckPrev;
  assign sckFall = selS & ~synced[0] &  sckPrev;

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selS,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       cmdMark,
  input  logic       cmdRead,
  output strobe_t    strb,
  output xferState_t state
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             byteEnd;

  assign byteEnd = sckRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN || !selS) begin
      state  <= ST_CMD;
      bitCnt <= '0;
    end else begin
      if (sckRise) bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
      if (byteEnd && state == ST_CMD) begin
        if (!cmdMark)     state <= ST_SKIP;
        else if (cmdRead) state <= ST_READ;
        else              state <= ST_WRITE;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftIn  = sckRise;
    strb.loadAddr = byteEnd && state == ST_CMD && cmdMark;
    strb.commitWr = byteEnd && state == ST_WRITE;
    strb.loadTx   = sckFall && state == ST_READ && bitCnt == '0;
    strb.shiftTx  = sckFall && state == ST_READ && bitCnt != '0;
    strb.clrOut   = !selS || state != ST_READ;
  end

endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regRaddr,
  output logic              regWe,
  output logic [ADDR_W-1:0] regWaddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              miso
);
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-2:0] txShift;
  logic [ADDR_W-1:0] addr;

  assign rxByte   = {rxShift, mosiS};
  assign regRaddr = addr;

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= rxByte[DATA_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) addr <= '0;
    else if (strb.loadAddr) addr <= rxByte[ADDR_W-1:0];
    else if (strb.commitWr || strb.loadTx) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWe    <= 1'b0;
      regWaddr <= '0;
      regWdata <= '0;
    end else begin
      regWe <= strb.commitWr;
      if (strb.commitWr) begin
        regWaddr <= addr;
        regWdata <= rxByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miso    <= 1'b0;
      txShift <= '0;
    end else if (strb.clrOut) begin
      miso    <= 1'b0;
    end else if (strb.loadTx) begin
      miso    <= regRdata[DATA_W-1];
      txShift <= regRdata[DATA_W-2:0];
    end else if (strb.shiftTx) begin
      miso    <= txShift[DATA_W-2];
      txShift <= {txShift[DATA_W-3:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MARK_BIT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSck,
  input  logic              spiMosi,
  input  logic              spiSel,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] regRaddr,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWe,
  output logic [ADDR_W-1:0] regWaddr,
  output logic [DATA_W-1:0] regWdata
);
  localparam int RD_BIT = DATA_W - 1;

  logic              mosiS, selS, sckRise, sckFall;
  logic [DATA_W-1:0] rxByte;
  strobe_t           strb;
  xferState_t        ctrlState;

  spi_reg_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .mosiIn(spiMosi), .selIn(spiSel),
    .mosiS(mosiS), .selS(selS), .sckRise(sckRise), .sckFall(sckFall)
  );

  spi_reg_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .selS(selS), .sckRise(sckRise), .sckFall(sckFall),
    .cmdMark(rxByte[MARK_BIT]), .cmdRead(rxByte[RD_BIT]),
    .strb(strb), .state(ctrlState)
  );

  spi_reg_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .strb(strb), .regRdata(regRdata),
    .rxByte(rxByte), .regRaddr(regRaddr), .regWe(regWe), .regWaddr(regWaddr),
    .regWdata(regWdata), .miso(spiMiso)
  );

endmodule

// File: rtl/spi_reg_chk.sv
module spi_reg_chk
  import spi_reg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       selS,
  input xferState_t state,
  input logic       regWe,
  input logic       spiMiso
);
  AST_MISO_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    !selS |=> !spiMiso); // R8
  AST_MISO_NOT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_READ) |=> !spiMiso); // R5
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R9
  AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> $past(state == ST_WRITE)); // R2
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> $past(selS)); // R6
endmodule

bind spi_reg_slave spi_reg_chk uChk (
  .clk(clk), .rstN(rstN), .selS(selS), .state(ctrlState),
  .regWe(regWe), .spiMiso(spiMiso)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiSck = 1'b0, spiMosi = 1'b0, spiSel = 1'b0;
  logic       spiMiso;
  logic [3:0] regRaddr, regWaddr;
  logic [7:0] regRdata, regWdata;
  logic       regWe;

  logic [7:0]  regFile [16];
  logic [7:0]  expFile [16];
  logic [11:0] expWrQ [$];
  int errCnt = 0, chkCnt = 0, selLowCnt = 0;

  always #2 clk = ~clk;

  assign regRdata = regFile[regRaddr];

  spi_reg_slave u0 (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiMosi(spiMosi), .spiSel(spiSel),
    .spiMiso(spiMiso), .regRaddr(regRaddr), .regRdata(regRdata), .regWe(regWe),
    .regWaddr(regWaddr), .regWdata(regWdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model on every clock: write port and idle MISO
  always @(negedge clk) begin
    if (spiSel) selLowCnt = 0; else selLowCnt++;
    if (rstN && selLowCnt > 6) chk(spiMiso == 1'b0, "R8", "miso while deselected", spiMiso, 0);
    if (rstN && regWe) begin
      if (expWrQ.size() == 0) chk(1'b0, "R9", "unexpected write strobe", {regWaddr, regWdata}, 0);
      else begin
        automatic logic [11:0] e = expWrQ.pop_front();
        chk({regWaddr, regWdata} == e, "R2", "write addr/data", {regWaddr, regWdata}, e);
      end
      regFile[regWaddr] = regWdata;
    end
  end

  task automatic spiByte(input logic [7:0] txb, input logic [7:0] expM, input int nBits,
                         input bit dropLast, input string req);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = txb[7-i];
      ticks(HALF);
      chk(spiMiso === expM[7-i], req, "miso bit", spiMiso, expM[7-i]);
      if (dropLast && i == nBits - 1) begin
        spiSck = 1'b1; spiSel = 1'b0;
        ticks(HALF); spiSck = 1'b0; ticks(2 * HALF);
      end else begin
        spiSck = 1'b1; ticks(HALF); spiSck = 1'b0;
      end
    end
  endtask

  task automatic selOn();
    spiSel = 1'b1; ticks(HALF);
  endtask

  task automatic selOff(input string req);
    ticks(HALF); spiSel = 1'b0; ticks(2 * HALF);
    chk(expWrQ.size() == 0, req, "pending expected writes", expWrQ.size(), 0);
  endtask

  task automatic doWrite(input logic [3:0] a0, input int n, input logic [7:0] seed,
                         input string req);
    logic [3:0] a = a0;
    selOn();
    spiByte(8'h10 | a0, 8'h00, 8, 1'b0, "R8");
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] d = seed + 8'(k * 37);
      expWrQ.push_back({a, d});
      expFile[a] = d;
      spiByte(d, 8'h00, 8, 1'b0, req);
      a = a + 1'b1;
    end
    selOff(req);
  endtask

  task automatic doRead(input logic [3:0] a0, input int n, input string req);
    logic [3:0] a = a0;
    selOn();
    spiByte(8'h90 | a0, 8'h00, 8, 1'b0, "R8");
    for (int k = 0; k < n; k++) begin
      spiByte(8'hFF, expFile[a], 8, 1'b0, req);   // MOSI ones must not write (R3)
      a = a + 1'b1;
    end
    selOff(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      regFile[i] = 8'(i * 17) ^ 8'hA5;
      expFile[i] = regFile[i];
    end
    ticks(3);
    chk(spiMiso == 1'b0, "R1", "miso in reset", spiMiso, 0);
    chk(regWe == 1'b0, "R1", "regWe in reset", regWe, 0);
    ticks(5); rstN = 1'b1; ticks(10);
    chk(spiMiso == 1'b0, "R1", "miso after reset", spiMiso, 0);
    chk(regWe == 1'b0, "R1", "regWe after reset", regWe, 0);

    doWrite(4'h2, 7, 8'h31, "R2");      // time block burst
    doRead(4'h2, 7, "R3");
    doRead(4'h0, 3, "R3");
    doWrite(4'hE, 3, 8'hC4, "R4");      // E, F, 0
    doRead(4'hF, 2, "R4");

    // marker bit clear: write-style and read-style commands both ignored
    selOn();
    spiByte(8'h05, 8'h00, 8, 1'b0, "R5");
    spiByte(8'h77, 8'h00, 8, 1'b0, "R5");
    spiByte(8'h12, 8'h00, 8, 1'b0, "R5");
    selOff("R5");
    selOn();
    spiByte(8'h85, 8'h00, 8, 1'b0, "R5");
    spiByte(8'h00, 8'h00, 8, 1'b0, "R5");
    selOff("R5");
    doRead(4'h5, 2, "R5");

    // partial byte dropped, complete byte kept
    selOn();
    spiByte(8'h13, 8'h00, 8, 1'b0, "R8");
    expWrQ.push_back({4'h3, 8'h5A}); expFile[3] = 8'h5A;
    spiByte(8'h5A, 8'h00, 8, 1'b0, "R6");
    spiByte(8'hC3, 8'h00, 5, 1'b0, "R6");
    selOff("R6");

    // eighth rising edge together with select falling
    selOn();
    spiByte(8'h14, 8'h00, 8, 1'b0, "R8");
    spiByte(8'h99, 8'h00, 8, 1'b1, "R10");
    chk(expWrQ.size() == 0, "R10", "pending writes", expWrQ.size(), 0);

    // fresh command after abandoned transfers
    doRead(4'h3, 2, "R7");
    doWrite(4'h9, 1, 8'h6E, "R7");
    doRead(4'h8, 3, "R7");

    ticks(20);
    for (int i = 0; i < 16; i++)
      chk(regFile[i] == expFile[i], "R2", "final register content", regFile[i], expFile[i]);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule